// File: doc/BRIEF.md
# Parallel Vector Bank Access Controller

This block is the per-bank side of a word-interleaved, multi-bank memory that serves strided vector requests. A request is a base word address, a stride in words and a length in elements. The same request goes to every bank at once. Each copy of this controller works out on its own which elements of the vector live in its bank. It then emits only those elements, one per handshake. The banks therefore walk a strided vector side by side rather than one element after another.

For each request the controller finds the smallest element index whose word address falls in its bank. It uses a small parallel residue search, pipelined over two stages. A second piece of logic turns the stride into a constant index step. Between two elements that land in the same bank, the index always grows by the bank count divided by gcd(stride mod bank count, bank count). The element loop adds that step to the index and adds a matching pre-shifted stride to the address. It presents each element's address and index under a valid/ready handshake. When the last element has been taken, or when no element hits the bank, it raises a one-cycle done pulse.

The bank count must be a power of two (default 16). The bank a controller serves is given on a static input, so one design serves every bank position.

Top module: `pva_bank_ctrl`

## Requirements
- R1: During and directly after reset, req_ready is 1, and elem_valid, done and no_hit are 0.
- R2: For each accepted request, the controller emits every element index i < length whose word address (base + i*stride) has its low log2(NUM_BANKS) bits equal to my_bank, each exactly once. It emits no other element.
- R3: Each emitted elem_addr equals base + elem_idx*stride, truncated to ADDR_W bits. Wrap-around past the top of the address space is included.
- R4: Elements come out in increasing index order. Consecutive indices differ by NUM_BANKS / gcd(stride mod NUM_BANKS, NUM_BANKS). A stride that is a multiple of NUM_BANKS (zero included) therefore sends every element to the bank of the base address, with a step of 1.
- R5: The first emitted index is the smallest matching index. If no index below the length matches, no element is emitted, and done is raised with no_hit = 1.
- R6: The first element, or the done pulse for a request with no hit, appears two clock edges after the accepting edge, so it is visible in the third cycle after acceptance.
- R7: While elem_valid is 1 and elem_ready is 0, elem_valid stays 1 and elem_addr and elem_idx hold their values.
- R8: done is a one-cycle pulse. It comes in the cycle after the handshake of the last element, or after the search for a request with no hit. no_hit is 1 only while done is 1.
- R9: req_ready is 0 from the accepting edge until the done pulse has ended. Requests offered during that time are ignored and produce no elements.
- R10: A request of length 0 emits no element and finishes with no_hit = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_bank | input | $clog2(NUM_BANKS) | Bank served by this instance, held static |
| req_valid | input | 1 | Vector request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_base | input | ADDR_W | Base word address |
| req_stride | input | ADDR_W | Stride in words |
| req_len | input | LEN_W | Number of elements |
| elem_valid | output | 1 | An element for this bank is presented |
| elem_ready | input | 1 | Consumer takes the presented element |
| elem_addr | output | ADDR_W | Word address of the element |
| elem_idx | output | LEN_W | Index of the element within the vector |
| done | output | 1 | One-cycle end-of-request pulse |
| no_hit | output | 1 | With done: no element of the vector hit this bank |

## Verification
The bench builds the controller with 8 banks, 32-bit addresses and 8-bit lengths. With 8 banks, small strides show every step class: odd strides (step 8), stride 2 (step 4), stride 0 or 8 (step 1). Banks that are never hit also appear. Lengths up to 40 make banks run through several steps, and a base near the top of the address space makes the addresses wrap. Running the same requests on every bank position, with a consumer that stalls irregularly, checks the bank split and the hold behaviour together.

// File: rtl/pva_bank_pkg.sv
package pva_bank_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_WALK   = 2'd2,
        ST_DONE   = 2'd3
    } walk_state_e;

    // Position of the lowest set bit of v, limited to cap (cap also for v == 0).
    function automatic int unsigned low_zero_run(logic [31:0] v, int unsigned cap);
        int unsigned n;
        n = cap;
        for (int k = 31; k >= 0; k--) begin
            if (v[k]) n = k;
        end
        return (n > cap) ? cap : n;
    endfunction

endpackage

// File: rtl/pva_next_hit.sv
// Stride -> constant index step between elements sharing one bank.
module pva_next_hit #(
    parameter int NUM_BANKS = 16,
    parameter int ADDR_W    = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int INC_W    = BANK_W + 1,
    localparam int LOG_W    = $clog2(BANK_W + 1)
) (
    input  logic [ADDR_W-1:0] stride,
    output logic [INC_W-1:0]  inc,
    output logic [LOG_W-1:0]  inc_log2
);
    import pva_bank_pkg::*;

    logic [BANK_W-1:0] s_lo;
    int unsigned       tz;

    always_comb begin
        s_lo     = stride[BANK_W-1:0];
        // gcd(s, N) = 2^tz for power-of-two N; step = N / gcd
        tz       = low_zero_run(32'(s_lo), BANK_W);
        inc_log2 = LOG_W'(BANK_W - tz);
        inc      = INC_W'(1) << inc_log2;
    end

endmodule

// File: rtl/pva_first_hit.sv
// Two-stage search for the first element index landing in this bank.
module pva_first_hit #(
    parameter int NUM_BANKS = 16,
    parameter int LEN_W     = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BANK_W-1:0] base_lo,
    input  logic [BANK_W-1:0] stride_lo,
    input  logic [BANK_W-1:0] bank,
    input  logic [LEN_W-1:0]  len,
    output logic              res_valid,
    output logic              res_hit,
    output logic [BANK_W-1:0] res_idx
);
    logic [NUM_BANKS-1:0] match_c;
    logic [NUM_BANKS-1:0] match_q;
    logic                 s1_valid;
    logic [LEN_W-1:0]     s1_len;
    logic                 found;
    logic [BANK_W-1:0]    low_idx;

    // Residue of element i, for i across one full period of N.
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_residue
        localparam logic [BANK_W-1:0] IV = BANK_W'(i);
        assign match_c[i] = ((base_lo + IV * stride_lo) == bank);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            match_q  <= '0;
            s1_len   <= '0;
        end else begin
            s1_valid <= start;
            if (start) begin
                match_q <= match_c;
                s1_len  <= len;
            end
        end
    end

    // Lowest set match bit
    always_comb begin
        found   = 1'b0;
        low_idx = '0;
        for (int k = NUM_BANKS - 1; k >= 0; k--) begin
            if (match_q[k]) begin
                found   = 1'b1;
                low_idx = BANK_W'(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_idx   <= '0;
        end else begin
            res_valid <= s1_valid;
            res_hit   <= found && (LEN_W'(low_idx) < s1_len);
            res_idx   <= low_idx;
        end
    end

endmodule

// File: rtl/pva_elem_walker.sv
// Index/address registers of the element loop.
module pva_elem_walker #(
    parameter int NUM_BANKS = 16,
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int INC_W    = BANK_W + 1,
    localparam int LOG_W    = $clog2(BANK_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BANK_W-1:0] load_idx,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [INC_W-1:0]  inc,
    input  logic [LOG_W-1:0]  inc_log2,
    input  logic [LEN_W-1:0]  len,
    input  logic              step,
    output logic [LEN_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [ADDR_W-1:0] addr_step;
    logic [INC_W-1:0]  inc_q;
    logic [LEN_W:0]    next_idx;

    assign next_idx = {1'b0, idx} + (LEN_W + 1)'(inc_q);
    assign last     = (next_idx >= {1'b0, len});

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            addr      <= '0;
            addr_step <= '0;
            inc_q     <= '0;
        end else if (load) begin
            idx       <= LEN_W'(load_idx);
            addr      <= base + ADDR_W'(load_idx) * stride;
            addr_step <= stride << inc_log2;
            inc_q     <= inc;
        end else if (step) begin
            idx       <= next_idx[LEN_W-1:0];
            addr      <= addr + addr_step;
        end
    end

endmodule

// File: rtl/pva_bank_ctrl.sv
module pva_bank_ctrl #(
    parameter int NUM_BANKS = 16,
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int INC_W    = BANK_W + 1,
    localparam int LOG_W    = $clog2(BANK_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] my_bank,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] req_stride,
    input  logic [LEN_W-1:0]  req_len,
    output logic              elem_valid,
    input  logic              elem_ready,
    output logic [ADDR_W-1:0] elem_addr,
    output logic [LEN_W-1:0]  elem_idx,
    output logic              done,
    output logic              no_hit
);
    import pva_bank_pkg::*;

    walk_state_e       state;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] stride_q;
    logic [LEN_W-1:0]  len_q;
    logic              nohit_q;

    logic              accept;
    logic              fh_valid;
    logic              fh_hit;
    logic [BANK_W-1:0] fh_idx;
    logic [INC_W-1:0]  inc;
    logic [LOG_W-1:0]  inc_log2;
    logic              walk_load;
    logic              walk_step;
    logic              walk_last;

    assign req_ready  = (state == ST_IDLE);
    assign elem_valid = (state == ST_WALK);
    assign done       = (state == ST_DONE);
    assign no_hit     = nohit_q;
    assign accept     = req_valid && req_ready;
    assign walk_load  = (state == ST_SEARCH) && fh_valid && fh_hit;
    assign walk_step  = elem_valid && elem_ready;

    pva_first_hit #(.NUM_BANKS(NUM_BANKS), .LEN_W(LEN_W)) u_first (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .base_lo   (req_base[BANK_W-1:0]),
        .stride_lo (req_stride[BANK_W-1:0]),
        .bank      (my_bank),
        .len       (req_len),
        .res_valid (fh_valid),
        .res_hit   (fh_hit),
        .res_idx   (fh_idx)
    );

    pva_next_hit #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_next (
        .stride   (stride_q),
        .inc      (inc),
        .inc_log2 (inc_log2)
    );

    pva_elem_walker #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walk (
        .clk      (clk),
        .rst      (rst),
        .load     (walk_load),
        .load_idx (fh_idx),
        .base     (base_q),
        .stride   (stride_q),
        .inc      (inc),
        .inc_log2 (inc_log2),
        .len      (len_q),
        .step     (walk_step),
        .idx      (elem_idx),
        .addr     (elem_addr),
        .last     (walk_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            base_q   <= '0;
            stride_q <= '0;
            len_q    <= '0;
            nohit_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        base_q   <= req_base;
                        stride_q <= req_stride;
                        len_q    <= req_len;
                        state    <= ST_SEARCH;
                    end
                end
                ST_SEARCH: begin
                    if (fh_valid) begin
                        if (fh_hit) begin
                            state <= ST_WALK;
                        end else begin
                            state   <= ST_DONE;
                            nohit_q <= 1'b1;
                        end
                    end
                end
                ST_WALK: begin
                    if (walk_step && walk_last) begin
                        state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state   <= ST_IDLE;
                    nohit_q <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pva_bank_ctrl_chk.sv
module pva_bank_ctrl_chk #(
    parameter int NUM_BANKS = 16,
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic              clk,
    input logic              rst,
    input logic [BANK_W-1:0] my_bank,
    input logic              req_valid,
    input logic              req_ready,
    input logic              elem_valid,
    input logic              elem_ready,
    input logic [ADDR_W-1:0] elem_addr,
    input logic [LEN_W-1:0]  elem_idx,
    input logic              done,
    input logic              no_hit,
    input logic [LEN_W-1:0]  len_q
);

    assert_bank_match_R2: assert property (@(posedge clk) disable iff (rst)
        elem_valid |-> (elem_addr[BANK_W-1:0] == my_bank));

    assert_idx_in_len_R2: assert property (@(posedge clk) disable iff (rst)
        elem_valid |-> (elem_idx < len_q));

    assert_idx_order_R4: assert property (@(posedge clk) disable iff (rst)
        (elem_valid && elem_ready) |=> (!elem_valid || (elem_idx > $past(elem_idx))));

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!elem_valid && !done) ##1 (!elem_valid && !done)
                                     ##1 (elem_valid || done));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (elem_valid && !elem_ready) |=>
            (elem_valid && $stable(elem_addr) && $stable(elem_idx)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_nohit_done_R8: assert property (@(posedge clk) disable iff (rst)
        no_hit |-> done);

    assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && (elem_valid || done)));

endmodule

bind pva_bank_ctrl pva_bank_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .my_bank    (my_bank),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .elem_valid (elem_valid),
    .elem_ready (elem_ready),
    .elem_addr  (elem_addr),
    .elem_idx   (elem_idx),
    .done       (done),
    .no_hit     (no_hit),
    .len_q      (len_q)
);

// File: tb/pva_bank_ctrl_tb.sv
module pva_bank_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int AW = 32;
    localparam int LW = 8;
    localparam int BW = $clog2(NB);

    typedef struct {
        logic [AW-1:0] addr;
        logic [LW-1:0] idx;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [BW-1:0] my_bank = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_base = '0;
    logic [AW-1:0] req_stride = '0;
    logic [LW-1:0] req_len = '0;
    logic          elem_valid;
    logic          elem_ready = 1'b1;
    logic [AW-1:0] elem_addr;
    logic [LW-1:0] elem_idx;
    logic          done;
    logic          no_hit;

    int   total = 0;
    int   bad = 0;
    exp_t exp_q[$];
    bit   exp_nohit = 1'b0;
    bit   track_lat = 1'b0;
    int   lat = 0;
    int   ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit   prev_stall = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [LW-1:0] prev_idx = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pva_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW), .LEN_W(LW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .my_bank    (my_bank),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_base   (req_base),
        .req_stride (req_stride),
        .req_len    (req_len),
        .elem_valid (elem_valid),
        .elem_ready (elem_ready),
        .elem_addr  (elem_addr),
        .elem_idx   (elem_idx),
        .done       (done),
        .no_hit     (no_hit)
    );

    task automatic check(input bit ok, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s", what);
        end
    endtask

    // Consumer ready, changed just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            elem_ready = (ready_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
        end
    end

    // Monitor: pops expected elements as they are handed over
    always @(negedge clk) begin
        if (!rst) begin
            if (track_lat) begin
                lat++;
                if (elem_valid || done) begin
                    check(lat == 3, $sformatf("R6 first result cycle act=%0d exp=3", lat));
                    track_lat = 1'b0;
                end
            end
            if (prev_stall)
                check(elem_valid && elem_addr == prev_addr && elem_idx == prev_idx,
                      $sformatf("R7 hold act=%0b/%h/%0d exp=1/%h/%0d", elem_valid,
                                elem_addr, elem_idx, prev_addr, prev_idx));
            prev_stall = elem_valid && !elem_ready;
            prev_addr  = elem_addr;
            prev_idx   = elem_idx;
            if (elem_valid)
                check(!req_ready, $sformatf("R9 req_ready while busy act=%0b exp=0", req_ready));
            if (elem_valid && elem_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, $sformatf("R2 unexpected element act idx=%0d addr=%h exp=none",
                                          elem_idx, elem_addr));
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(elem_idx == e.idx,
                          $sformatf("R4 index act=%0d exp=%0d", elem_idx, e.idx));
                    check(elem_addr == e.addr,
                          $sformatf("R3 address act=%h exp=%h", elem_addr, e.addr));
                end
            end
            if (done) begin
                check(exp_q.size() == 0,
                      $sformatf("R2 missing elements at done act=%0d exp=0", exp_q.size()));
                check(no_hit == exp_nohit,
                      $sformatf("R5 no_hit act=%0b exp=%0b", no_hit, exp_nohit));
                exp_q.delete();
            end else begin
                check(!no_hit, $sformatf("R8 no_hit outside done act=%0b exp=0", no_hit));
            end
        end
    end

    // Driver: model the bank split, push expectations, offer the request
    task automatic run_vec(input int bank, input logic [AW-1:0] base,
                           input logic [AW-1:0] stride, input int len, input bit junk);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        my_bank = BW'(bank);
        for (int i = 0; i < len; i++) begin
            logic [AW-1:0] a;
            exp_t e;
            a = base + AW'(i) * stride;
            if (a[BW-1:0] == BW'(bank)) begin
                e.addr = a;
                e.idx  = LW'(i);
                exp_q.push_back(e);
            end
        end
        exp_nohit  = (exp_q.size() == 0);
        req_base   = base;
        req_stride = stride;
        req_len    = LW'(len);
        req_valid  = 1'b1;
        @(posedge clk);
        #1;
        track_lat = 1'b1;
        lat       = 0;
        if (junk) begin
            // R9: a second request offered while busy must be ignored
            req_base   = 32'h0000_5A50;
            req_stride = 32'd1;
            req_len    = 8'd20;
        end else begin
            req_valid = 1'b0;
        end
        @(negedge clk);
        while (!done) @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready && !elem_valid && !done && !no_hit,
              $sformatf("R1 in reset act=%0b%0b%0b%0b exp=1000", req_ready, elem_valid, done, no_hit));
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !elem_valid && !done && !no_hit,
              $sformatf("R1 after reset act=%0b%0b%0b%0b exp=1000", req_ready, elem_valid, done, no_hit));

        // R4: stride 2 -> even banks, step 4 (bank 0: 0,4,8,12; bank 2: 1,5,9,13)
        run_vec(0, 1024, 2, 16, 1'b0);
        run_vec(2, 1024, 2, 16, 1'b0);
        // R5: odd bank never hit by stride 2
        run_vec(1, 1024, 2, 16, 1'b0);
        // R4: stride 3 visits banks 0,3,6,1,4,7,2,5
        for (int b = 0; b < NB; b++) run_vec(b, 1024, 3, 8, 1'b0);
        // R4: stride 0 and stride multiple of the bank count
        run_vec(5, 1029, 0, 5, 1'b0);
        run_vec(4, 1029, 0, 5, 1'b0);
        run_vec(5, 1029, 8, 6, 1'b0);
        // R10: empty vector
        run_vec(0, 1024, 1, 0, 1'b0);
        // R5: first hit beyond the length
        run_vec(5, 0, 1, 3, 1'b0);
        // R9: request offered while busy
        run_vec(3, 11, 5, 24, 1'b1);
        run_vec(3, 0, 1, 8, 1'b0);

        // R7: irregular consumer stalls, long vectors, wrapping addresses (R3)
        ready_mode = 1;
        for (int b = 0; b < NB; b++) begin
            run_vec(b, 7, 13, 40, 1'b0);
            run_vec(b, 32'hFFFF_FFF0, 6, 30, 1'b0);
            run_vec(b, 100, 4, 33, 1'b0);
        end
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule